// File: doc/BRIEF.md
# Second-Level Cache Error Capture and Trap Steering

This block sits beside a four-bank second-level cache and turns reported cache errors into logged state and trap requests. Each request carries a 16-byte block address, an access kind, the requesting thread and, when the cache arrays detected a fault, an error flag with its class (correctable or uncorrectable). The bank is picked from the line address. That bank's status and address registers are overwritten with a description of the error. A single-cycle trap request then goes out with a target thread and a trap kind.

Partial stores and accesses to odd-numbered 64-byte lines are not trapped on the requester. They go to a steering thread that is configured for each bank. For a steered uncorrectable error that is not a partial store, the logged address points at the next 16-byte block of the same line. The block also holds one poisoned line address per error class, recorded when a load or fetch hits an error. A later load, fetch, atomic or partial store to that line raises the error again without an error flag on the request. A full store to the line wipes the record.

Top module: `l2_err_capture`

## Requirements
- R1: Access kind encoding on `req_kind` is load=0, store=1, atomic=2, partial store=3, fetch=4. An error on a request to address bits [7:6]=b updates only bank b's status and address registers. The new values are visible in the cycle after the request, and the other banks keep their values.
- R2: A bank status word holds the requester thread in bits [TID_W-1:0], the read/write bit in [TID_W], the uncorrectable-valid flag in [TID_W+1] and the correctable-valid flag in [TID_W+2]. The read/write bit is set for an atomic or partial store unless the request is steered.
- R3: A correctable error raises trap kind 0 (ECC) only when `core_ce_en` and the bank's correctable enable are both 1. The target is the requester unless the request is steered.
- R4: A request is steered when it is a partial store or address bit 6 is 1. A steered trap targets the bank's steering thread, and the read/write bit in the logged status is 0.
- R5: An uncorrectable error traps only when the bank's uncorrectable enable is 1. A steered one raises kind 3 (data error) whatever `core_ue_en` is. A non-steered one needs `core_ue_en` and raises kind 2 on a fetch and kind 1 otherwise.
- R6: The logged address is the line address with bits [5:0] zero. For a steered uncorrectable error that is not a partial store, bits [5:4] are the request's bits [5:4] plus one, modulo 4.
- R7: An uncorrectable error on a load or fetch records its line as the uncorrectable poison. A later load, fetch, atomic or partial store to that line without `req_err` raises an uncorrectable error again.
- R8: A correctable error on a load or fetch records its line as the correctable poison. A correctable error on an atomic or partial store records nothing. On a plain access that matches both records, the correctable record wins.
- R9: A store (kind 1) to a recorded line clears that record and raises no error from it.
- R10: While any bit of `bank_disable` is 1, no status or address update, trap or poison recording takes place.
- R11: `trap_valid` is high only in the cycle after an accepted error and is low after idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W-4 | Physical address bits [ADDR_W-1:4] (16-byte block) |
| req_kind | input | 3 | Access kind, see R1 |
| req_tid | input | TID_W | Requesting thread |
| req_err | input | 1 | Error detected on this request |
| req_ue | input | 1 | Error class: 1 uncorrectable, 0 correctable |
| core_ce_en | input | 1 | Core enable for correctable traps |
| core_ue_en | input | 1 | Core enable for uncorrectable traps |
| bank_ce_en | input | NUM_BANKS | Per-bank correctable trap enable |
| bank_ue_en | input | NUM_BANKS | Per-bank uncorrectable trap enable |
| bank_disable | input | NUM_BANKS | Per-bank cache-disable bits |
| bank_steer_tid | input | NUM_BANKS*TID_W | Per-bank steering thread |
| trap_valid | output | 1 | One-cycle trap request |
| trap_tid | output | TID_W | Trap target thread |
| trap_kind | output | 2 | 0 ECC, 1 data access, 2 instruction access, 3 data error |
| bank_status | output | NUM_BANKS*(TID_W+3) | Status registers, bank 0 in the low bits |
| bank_addr | output | NUM_BANKS*ADDR_W | Logged address registers, bank 0 in the low bits |
| ce_poison_valid | output | 1 | Correctable poison record held |
| ce_poison_addr | output | ADDR_W | Correctable poison line address |
| ue_poison_valid | output | 1 | Uncorrectable poison record held |
| ue_poison_addr | output | ADDR_W | Uncorrectable poison line address |

## Verification
The bench builds the block with its defaults: 40-bit addresses, 6-bit thread IDs and four banks. With these values every bank index in bits [7:6] and the odd-line bit are reachable, and steering threads can be told apart from requesters. Random addresses come from four line tags in a small pool, so poison hits, re-detection and store clears happen often. The wrap of bits [5:4] from 3 to 0 is driven directly.

// File: rtl/l2ec_pkg.sv
package l2ec_pkg;

    localparam int LINE_LSB = 6;

    typedef enum logic [2:0] {
        ACC_LOAD   = 3'd0,
        ACC_STORE  = 3'd1,
        ACC_ATOMIC = 3'd2,
        ACC_PSTORE = 3'd3,
        ACC_FETCH  = 3'd4
    } acc_kind_e;

    typedef enum logic [1:0] {
        TRAP_ECC  = 2'd0,
        TRAP_DACC = 2'd1,
        TRAP_IACC = 2'd2,
        TRAP_DERR = 2'd3
    } trap_kind_e;

endpackage

// File: rtl/l2ec_poison_slot.sv
// One remembered poisoned line; set wins over clear.
module l2ec_poison_slot #(
    parameter int LINE_W = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic [LINE_W-1:0] line_i,
    output logic              hit_o,
    output logic              valid_o,
    output logic [LINE_W-1:0] line_o
);
    typedef struct packed {
        logic              v;
        logic [LINE_W-1:0] line;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (set_i) begin
            slot_d.v    = 1'b1;
            slot_d.line = line_i;
        end else if (clr_i) begin
            slot_d.v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign hit_o   = slot_q.v && (slot_q.line == line_i);
    assign valid_o = slot_q.v;
    assign line_o  = slot_q.line;
endmodule

// File: rtl/l2ec_decode.sv
// Classifies one request: error acceptance, status word, reported address,
// trap target and kind, poison record updates.
module l2ec_decode
    import l2ec_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int TID_W  = 6
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:4] req_blk,
    input  logic [2:0]        req_kind,
    input  logic [TID_W-1:0]  req_tid,
    input  logic              req_err,
    input  logic              req_ue,
    input  logic              ce_hit,
    input  logic              ue_hit,
    input  logic              any_disable,
    input  logic              core_ce_en,
    input  logic              core_ue_en,
    input  logic              bank_ce_en,
    input  logic              bank_ue_en,
    input  logic [TID_W-1:0]  steer_tid,
    output logic              err,
    output logic [TID_W+2:0]  stat,
    output logic [ADDR_W-1:0] rep_addr,
    output logic              trap_v,
    output logic [TID_W-1:0]  trap_tid,
    output logic [1:0]        trap_kind,
    output logic              set_ce,
    output logic              set_ue,
    output logic              clr_ce,
    output logic              clr_ue
);
    acc_kind_e kind;
    logic      is_store, is_pst, rd_like, redet, ue, steer, rw;

    always_comb begin
        kind     = acc_kind_e'(req_kind);
        is_store = (kind == ACC_STORE);
        is_pst   = (kind == ACC_PSTORE);
        rd_like  = (kind == ACC_LOAD) || (kind == ACC_FETCH);
        redet    = !is_store && (ce_hit || ue_hit);
        err      = req_valid && !any_disable && (req_err || redet);
        // a plain access matching both records reports the correctable one
        ue       = req_err ? req_ue : !ce_hit;
        steer    = is_pst || req_blk[LINE_LSB];
        rw       = ((kind == ACC_ATOMIC) || is_pst) && !steer;
        stat     = {!ue, ue, rw, req_tid};

        rep_addr = '0;
        rep_addr[ADDR_W-1:LINE_LSB] = req_blk[ADDR_W-1:LINE_LSB];
        if (ue && steer && !is_pst)
            rep_addr[5:4] = req_blk[5:4] + 2'd1;

        trap_v    = 1'b0;
        trap_tid  = req_tid;
        trap_kind = TRAP_ECC;
        if (!ue) begin
            trap_v   = core_ce_en && bank_ce_en;
            trap_tid = steer ? steer_tid : req_tid;
        end else if (bank_ue_en) begin
            if (steer) begin
                trap_v    = 1'b1;
                trap_tid  = steer_tid;
                trap_kind = TRAP_DERR;
            end else begin
                trap_v    = core_ue_en;
                trap_kind = (kind == ACC_FETCH) ? TRAP_IACC : TRAP_DACC;
            end
        end
        trap_v = trap_v && err;

        set_ce = err && !ue && rd_like;
        set_ue = err && ue && rd_like;
        clr_ce = req_valid && is_store && ce_hit;
        clr_ue = req_valid && is_store && ue_hit;
    end
endmodule

// File: rtl/l2_err_capture.sv
module l2_err_capture
    import l2ec_pkg::*;
#(
    parameter int ADDR_W    = 40,
    parameter int TID_W     = 6,
    parameter int NUM_BANKS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic [ADDR_W-1:4]              req_addr,
    input  logic [2:0]                     req_kind,
    input  logic [TID_W-1:0]               req_tid,
    input  logic                           req_err,
    input  logic                           req_ue,
    input  logic                           core_ce_en,
    input  logic                           core_ue_en,
    input  logic [NUM_BANKS-1:0]           bank_ce_en,
    input  logic [NUM_BANKS-1:0]           bank_ue_en,
    input  logic [NUM_BANKS-1:0]           bank_disable,
    input  logic [NUM_BANKS*TID_W-1:0]     bank_steer_tid,
    output logic                           trap_valid,
    output logic [TID_W-1:0]               trap_tid,
    output logic [1:0]                     trap_kind,
    output logic [NUM_BANKS*(TID_W+3)-1:0] bank_status,
    output logic [NUM_BANKS*ADDR_W-1:0]    bank_addr,
    output logic                           ce_poison_valid,
    output logic [ADDR_W-1:0]              ce_poison_addr,
    output logic                           ue_poison_valid,
    output logic [ADDR_W-1:0]              ue_poison_addr
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int STAT_W = TID_W + 3;
    localparam int LINE_W = ADDR_W - LINE_LSB;
    localparam int NUM_CLS = 2;

    typedef struct packed {
        logic [NUM_BANKS-1:0][STAT_W-1:0] stat;
        logic [NUM_BANKS-1:0][ADDR_W-1:0] addr;
        logic                             trap_v;
        logic [TID_W-1:0]                 trap_tid;
        logic [1:0]                       trap_kind;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [BANK_W-1:0]              bank_sel;
    logic [LINE_W-1:0]              req_line;
    logic                           err, d_trap_v;
    logic [STAT_W-1:0]              d_stat;
    logic [ADDR_W-1:0]              d_addr;
    logic [TID_W-1:0]               d_trap_tid;
    logic [1:0]                     d_trap_kind;
    logic                           set_ce, set_ue, clr_ce, clr_ue;
    logic [NUM_CLS-1:0]             p_set, p_clr, p_hit, p_valid;
    logic [NUM_CLS-1:0][LINE_W-1:0] p_line;

    assign bank_sel = req_addr[LINE_LSB +: BANK_W];
    assign req_line = req_addr[ADDR_W-1:LINE_LSB];
    assign p_set    = {set_ue, set_ce};
    assign p_clr    = {clr_ue, clr_ce};

    // slot 0 keeps the correctable record, slot 1 the uncorrectable one
    for (genvar g = 0; g < NUM_CLS; g++) begin : g_poison
        l2ec_poison_slot #(.LINE_W(LINE_W)) slot_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (p_set[g]),
            .clr_i   (p_clr[g]),
            .line_i  (req_line),
            .hit_o   (p_hit[g]),
            .valid_o (p_valid[g]),
            .line_o  (p_line[g])
        );
    end

    l2ec_decode #(.ADDR_W(ADDR_W), .TID_W(TID_W)) decode_i (
        .req_valid   (req_valid),
        .req_blk     (req_addr),
        .req_kind    (req_kind),
        .req_tid     (req_tid),
        .req_err     (req_err),
        .req_ue      (req_ue),
        .ce_hit      (p_hit[0]),
        .ue_hit      (p_hit[1]),
        .any_disable (|bank_disable),
        .core_ce_en  (core_ce_en),
        .core_ue_en  (core_ue_en),
        .bank_ce_en  (bank_ce_en[bank_sel]),
        .bank_ue_en  (bank_ue_en[bank_sel]),
        .steer_tid   (bank_steer_tid[bank_sel*TID_W +: TID_W]),
        .err         (err),
        .stat        (d_stat),
        .rep_addr    (d_addr),
        .trap_v      (d_trap_v),
        .trap_tid    (d_trap_tid),
        .trap_kind   (d_trap_kind),
        .set_ce      (set_ce),
        .set_ue      (set_ue),
        .clr_ce      (clr_ce),
        .clr_ue      (clr_ue)
    );

    always_comb begin
        regs_d           = regs_q;
        regs_d.trap_v    = d_trap_v;
        regs_d.trap_tid  = d_trap_tid;
        regs_d.trap_kind = d_trap_kind;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (err && (bank_sel == BANK_W'(b))) begin
                regs_d.stat[b] = d_stat;
                regs_d.addr[b] = d_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign trap_valid      = regs_q.trap_v;
    assign trap_tid        = regs_q.trap_tid;
    assign trap_kind       = regs_q.trap_kind;
    assign bank_status     = regs_q.stat;
    assign bank_addr       = regs_q.addr;
    assign ce_poison_valid = p_valid[0];
    assign ce_poison_addr  = {p_line[0], {LINE_LSB{1'b0}}};
    assign ue_poison_valid = p_valid[1];
    assign ue_poison_addr  = {p_line[1], {LINE_LSB{1'b0}}};
endmodule

// File: rtl/l2ec_checker.sv
module l2ec_checker
    import l2ec_pkg::*;
#(
    parameter int LINE_W    = 34,
    parameter int NUM_BANKS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [LINE_W-1:0]    req_line,
    input logic                 req_odd,
    input logic [2:0]           req_kind,
    input logic [NUM_BANKS-1:0] bank_disable,
    input logic                 core_ce_en,
    input logic                 trap_valid,
    input logic [1:0]           trap_kind,
    input logic                 ce_poison_valid,
    input logic                 ue_poison_valid,
    input logic [LINE_W-1:0]    ue_poison_line
);
    assert_trap_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> ($past(req_valid) && ($past(bank_disable) == '0)));

    assert_ecc_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && trap_kind == TRAP_ECC) |-> $past(core_ce_en));

    assert_steer_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && trap_kind == TRAP_DERR) |->
            ($past(req_odd) || ($past(req_kind) == ACC_PSTORE)));

    assert_ue_record_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ue_poison_valid) |->
            (($past(req_kind) == ACC_LOAD) || ($past(req_kind) == ACC_FETCH)));

    assert_ce_record_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce_poison_valid) |->
            (($past(req_kind) == ACC_LOAD) || ($past(req_kind) == ACC_FETCH)));

    assert_store_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_valid) && ($past(req_kind) == ACC_STORE) && $past(ue_poison_valid)
         && ($past(req_line) == $past(ue_poison_line))) |-> !ue_poison_valid);
endmodule

bind l2_err_capture l2ec_checker #(.LINE_W(ADDR_W-6), .NUM_BANKS(NUM_BANKS)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_line        (req_addr[ADDR_W-1:6]),
    .req_odd         (req_addr[6]),
    .req_kind        (req_kind),
    .bank_disable    (bank_disable),
    .core_ce_en      (core_ce_en),
    .trap_valid      (trap_valid),
    .trap_kind       (trap_kind),
    .ce_poison_valid (ce_poison_valid),
    .ue_poison_valid (ue_poison_valid),
    .ue_poison_line  (ue_poison_addr[ADDR_W-1:6])
);

// File: tb/l2_err_capture_tb_top.sv
`timescale 1ns/1ps
module l2_err_capture_tb_top;
    logic clk = 1'b0;
    logic rst_n;
    always #4 clk = ~clk;

    logic        req_valid, req_err, req_ue, core_ce_en, core_ue_en;
    logic [39:4] req_addr;
    logic [2:0]  req_kind;
    logic [5:0]  req_tid;
    logic [3:0]  bank_ce_en, bank_ue_en, bank_disable;
    logic [23:0] bank_steer_tid;
    logic        trap_valid, ce_poison_valid, ue_poison_valid;
    logic [5:0]  trap_tid;
    logic [1:0]  trap_kind;
    logic [35:0] bank_status;
    logic [159:0] bank_addr;
    logic [39:0] ce_poison_addr, ue_poison_addr;

    l2_err_capture dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .req_tid(req_tid), .req_err(req_err), .req_ue(req_ue),
        .core_ce_en(core_ce_en), .core_ue_en(core_ue_en), .bank_ce_en(bank_ce_en),
        .bank_ue_en(bank_ue_en), .bank_disable(bank_disable), .bank_steer_tid(bank_steer_tid),
        .trap_valid(trap_valid), .trap_tid(trap_tid), .trap_kind(trap_kind),
        .bank_status(bank_status), .bank_addr(bank_addr),
        .ce_poison_valid(ce_poison_valid), .ce_poison_addr(ce_poison_addr),
        .ue_poison_valid(ue_poison_valid), .ue_poison_addr(ue_poison_addr)
    );

    int n_chk = 0;
    int n_bad = 0;
    string step;

    // reference state
    logic [8:0]  m_stat [4];
    logic [39:0] m_addr [4];
    logic        m_cev, m_uev;
    logic [33:0] m_cel, m_uel;
    logic        e_tv;
    logic [5:0]  e_tt;
    logic [1:0]  e_tk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%h expected=%h", tag, step, act, exp);
        end
    endtask

    task automatic model_step();
        logic [1:0]  bk;
        logic [33:0] line;
        logic        steer, ch, uh, red, fire, cu;
        bk    = req_addr[7:6];
        line  = req_addr[39:6];
        steer = (req_kind == 3'd3) || req_addr[6];
        ch    = m_cev && (m_cel == line);
        uh    = m_uev && (m_uel == line);
        red   = (req_kind != 3'd1) && (ch || uh);
        fire  = req_valid && (bank_disable == 4'd0) && (req_err || red);
        cu    = req_err ? req_ue : !ch;
        e_tv = 1'b0; e_tt = 6'd0; e_tk = 2'd0;
        if (fire) begin
            m_stat[bk] = {!cu, cu, ((req_kind == 3'd2 || req_kind == 3'd3) && !steer), req_tid};
            m_addr[bk] = {line, 6'd0};
            if (cu && steer && req_kind != 3'd3)
                m_addr[bk][5:4] = req_addr[5:4] + 2'd1;
            if (!cu) begin
                e_tv = core_ce_en && bank_ce_en[bk];
                e_tt = steer ? bank_steer_tid[bk*6 +: 6] : req_tid;
                e_tk = 2'd0;
            end else if (bank_ue_en[bk]) begin
                if (steer) begin
                    e_tv = 1'b1; e_tt = bank_steer_tid[bk*6 +: 6]; e_tk = 2'd3;
                end else begin
                    e_tv = core_ue_en; e_tt = req_tid;
                    e_tk = (req_kind == 3'd4) ? 2'd2 : 2'd1;
                end
            end
            if (req_kind == 3'd0 || req_kind == 3'd4) begin
                if (cu) begin m_uev = 1'b1; m_uel = line; end
                else    begin m_cev = 1'b1; m_cel = line; end
            end
        end
        if (req_valid && req_kind == 3'd1) begin
            if (ch) m_cev = 1'b0;
            if (uh) m_uev = 1'b0;
        end
    endtask

    task automatic compare_all();
        chk("R3 R5 R10 R11 trap",
            {61'd0, trap_valid} << 8 | (trap_valid ? {trap_tid, trap_kind} : 8'd0),
            {61'd0, e_tv} << 8 | (e_tv ? {e_tt, e_tk} : 8'd0));
        for (int b = 0; b < 4; b++) begin
            chk("R1 R2 R4 bank status", {55'd0, bank_status[b*9 +: 9]}, {55'd0, m_stat[b]});
            chk("R1 R6 bank address", {24'd0, bank_addr[b*40 +: 40]}, {24'd0, m_addr[b]});
        end
        chk("R8 R9 correctable record", {23'd0, ce_poison_valid, ce_poison_valid ? ce_poison_addr : 40'd0},
            {23'd0, m_cev, m_cev ? {m_cel, 6'd0} : 40'd0});
        chk("R7 R9 uncorrectable record", {23'd0, ue_poison_valid, ue_poison_valid ? ue_poison_addr : 40'd0},
            {23'd0, m_uev, m_uev ? {m_uel, 6'd0} : 40'd0});
    endtask

    task automatic drive(input string s, input logic v, input logic [39:0] a, input logic [2:0] k,
                         input logic [5:0] t, input logic e, input logic u);
        @(negedge clk);
        step = s;
        req_valid = v; req_addr = a[39:4]; req_kind = k; req_tid = t; req_err = e; req_ue = u;
        model_step();
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] pool [4];
        void'($urandom(32'd2024));
        pool[0] = 32'h1000_0000; pool[1] = 32'h2000_0001;
        pool[2] = 32'h3000_0002; pool[3] = 32'h4000_0003;
        rst_n = 1'b0;
        req_valid = 0; req_addr = '0; req_kind = 0; req_tid = 0; req_err = 0; req_ue = 0;
        core_ce_en = 1; core_ue_en = 1; bank_ce_en = 4'hF; bank_ue_en = 4'hF;
        bank_disable = 4'h0; bank_steer_tid = {6'h13, 6'h12, 6'h11, 6'h10};
        for (int b = 0; b < 4; b++) begin m_stat[b] = '0; m_addr[b] = '0; end
        m_cev = 0; m_uev = 0; m_cel = '0; m_uel = '0; e_tv = 0; e_tt = 0; e_tk = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        step = "reset R1";
        compare_all();

        // correctable, even line, load: ECC to requester, record (R3 R8)
        drive("R3 ce load even", 1, 40'h10_0000_0080, 3'd0, 6'd5, 1, 0);
        // correctable atomic even line: rw set, no record (R2 R8)
        drive("R2 ce atomic even", 1, 40'h20_0000_0020, 3'd2, 6'd7, 1, 0);
        // correctable partial store: steered, rw cleared (R4)
        drive("R4 ce pstore", 1, 40'h20_0000_0000, 3'd3, 6'd8, 1, 0);
        // correctable load odd line bank 1: steered (R4)
        drive("R4 ce load odd", 1, 40'h30_0000_0050, 3'd0, 6'd9, 1, 0);
        // bank correctable enable off: status updates, no trap (R3)
        bank_ce_en = 4'b1011;
        drive("R3 ce bank enable off", 1, 40'h30_0000_0090, 3'd1, 6'd2, 1, 0);
        bank_ce_en = 4'hF;
        // uncorrectable load even: data access (R5 R7)
        drive("R5 ue load even", 1, 40'h40_0000_0010, 3'd0, 6'd3, 1, 1);
        // uncorrectable fetch: instruction access (R5 R7)
        drive("R5 ue fetch", 1, 40'h50_0000_0100, 3'd4, 6'd4, 1, 1);
        // steered uncorrectable, bits [5:4]=3 wraps to 0, core enable off (R5 R6)
        core_ue_en = 0;
        drive("R6 ue steered wrap", 1, 40'h60_0000_00F0, 3'd0, 6'd6, 1, 1);
        // steered uncorrectable partial store: no rewrite (R6)
        drive("R6 ue pstore", 1, 40'h60_0000_0060, 3'd3, 6'd6, 1, 1);
        // non-steered uncorrectable with core enable off: no trap (R5)
        drive("R5 ue core off", 1, 40'h60_0000_0000, 3'd1, 6'd1, 1, 1);
        core_ue_en = 1;
        // uncorrectable record now line of 0x60_0000_00C0? only loads record; refresh with fetch
        drive("R7 ue fetch record", 1, 40'h70_0000_0080, 3'd4, 6'd11, 1, 1);
        // plain partial store to poisoned line re-raises (R7)
        drive("R7 redetect pstore", 1, 40'h70_0000_00A0, 3'd3, 6'd12, 0, 0);
        // plain load re-raises (R7)
        drive("R7 redetect load", 1, 40'h70_0000_0090, 3'd0, 6'd13, 0, 0);
        // full store clears record (R9)
        drive("R9 store clears", 1, 40'h70_0000_00B0, 3'd1, 6'd14, 0, 0);
        drive("R9 after clear", 1, 40'h70_0000_0080, 3'd0, 6'd14, 0, 0);
        // correctable record wins over uncorrectable on plain load (R8)
        drive("R8 ce record", 1, 40'h70_0000_0080, 3'd0, 6'd15, 1, 0);
        drive("R8 ue record", 1, 40'h70_0000_0080, 3'd4, 6'd15, 1, 1);
        drive("R8 priority", 1, 40'h70_0000_0080, 3'd0, 6'd16, 0, 0);
        // cache disabled: nothing changes (R10)
        bank_disable = 4'b0100;
        drive("R10 disabled", 1, 40'h11_0000_0040, 3'd0, 6'd17, 1, 1);
        bank_disable = 4'h0;
        // idle: trap drops (R11)
        drive("R11 idle", 0, 40'h0, 3'd0, 6'd0, 0, 0);
        drive("R11 idle 2", 0, 40'h0, 3'd0, 6'd0, 1, 1);

        for (int i = 0; i < 3000; i++) begin
            logic [39:0] a;
            a = {pool[$urandom % 4], $urandom % 256};
            core_ce_en   = ($urandom % 8) != 0;
            core_ue_en   = ($urandom % 8) != 0;
            bank_ce_en   = 4'($urandom) | 4'($urandom);
            bank_ue_en   = 4'($urandom) | 4'($urandom);
            bank_disable = (($urandom % 16) == 0) ? 4'($urandom) : 4'h0;
            bank_steer_tid = 24'($urandom);
            drive("R1 random", ($urandom % 8) != 0, a, 3'($urandom % 5), 6'($urandom),
                  ($urandom % 10) < 6, 1'($urandom));
        end

        summary();
        $finish;
    end
endmodule